// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a slave on a two-wire serial bus. It gives a host read and write access to a small bank of 8-bit control registers, such as per-output clock enables. Both bus lines are oversampled on the system clock. The block detects start, repeated start and stop conditions, compares the incoming address with its own, and pulls SDA low through an active-high output enable whenever it acknowledges or sends a zero bit. The register contents are presented to the rest of the chip as one flat parallel vector. Every register returns to a parameterised default value at reset.

The first byte after the address is a command byte. Its bit 7 selects the transfer mode and bits 6:0 give the starting register offset.

In byte mode a single register is accessed. In block mode:
- a write carries a byte count ahead of its data;
- a read returns a byte count first and then the registers in ascending offset order.

A read is made by writing the command byte, issuing a repeated start, and then addressing the block with the read bit set. The host may end any transfer after a whole byte. Each data byte takes effect only once it is complete.

Top module: `smb_regfile`

## Requirements
- R1: After reset every register holds its default value, register i being RST_VAL[8i+7:8i], and SDA is released (sda_oe = 0).
- R2: An address byte whose upper seven bits equal 0x6B is acknowledged (SDA low during the ninth clock). Any other address is not acknowledged, and SDA stays released for every following byte until the next start or stop.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start or repeated start at any point, including inside a byte, restarts address reception.
- R4: A command byte with bit 7 = 1 selects byte mode, with bits 6:0 as the register offset. The next data byte is acknowledged and written to that register. Any further data byte in the same transfer is not acknowledged and not written.
- R5: After a byte-mode command, a repeated start and address 0xD7, the block sends the addressed register most significant bit first.
- R6: A command byte with bit 7 = 0 selects block mode. The next byte is a count N, and the following N data bytes are acknowledged and written to consecutive offsets starting at the command offset. Data bytes beyond N are not acknowledged and not written.
- R7: A block read first returns the count NREG - offset, or 0 when the offset is at or beyond NREG. It then returns the registers from the offset upwards, until the host answers a byte with a NACK.
- R8: Offsets at or beyond NREG read as 0x00. Writes to them are acknowledged and have no effect.
- R9: A stop after any complete byte of a block write leaves exactly the bytes already acknowledged written. No other register changes.
- R10: SDA driven by the block changes only while SCL is low, apart from release on a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | NREG*8 | Register contents; register i occupies bits 8i+7:8i |

## Verification
The bench builds the block with its defaults: eight registers, address 0x6B and two synchroniser stages. It overrides the reset image with a mixed pattern, so that every register starts distinct and nonzero except one, which makes stray writes visible. With eight registers and a seven-bit offset, a single command can point inside the bank, at its last register, or well past it. This puts the count calculation, the out-of-bank read value and the NACK past the count all within reach of short transfers. The serial clock runs at one twenty-fourth of the system clock, which leaves room for the synchroniser delay before each SCL edge.

// File: rtl/smb_pkg.sv
package smb_pkg;

  // Protocol engine states
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,   // receiving address byte
    ST_CMD,    // receiving command byte
    ST_CNT,    // receiving block byte count
    ST_WDAT,   // receiving write data
    ST_ACK,    // slave acknowledge bit
    ST_TX,     // slave sending a byte
    ST_MACK,   // host acknowledge bit after a sent byte
    ST_SKIP    // ignoring the bus until start or stop
  } smb_st_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;
  logic              scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // Data edges count only while the clock line is high on both samples
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int                NREG    = 8,
  parameter int                PW      = 8,
  parameter logic [NREG*8-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [PW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_o
);

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG*8-1:0] bank_q;
  logic [NREG-1:0]   hit;

  // One decoded write enable per register
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = wr_en && (wr_addr == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= RST_VAL;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (hit[i]) bank_q[i*8 +: 8] <= wr_data;
      end
    end
  end

  logic [IW-1:0] rd_idx;
  assign rd_idx  = rd_addr[IW-1:0];
  assign rd_data = (rd_addr < PW'(NREG)) ? bank_q[rd_idx*8 +: 8] : 8'h00;
  assign regs_o  = bank_q;

endmodule

// File: rtl/smb_protocol.sv
module smb_protocol
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6B,
  parameter int         NREG     = 8,
  parameter int         PW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_addr,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe,
  output smb_st_e       st_o
);

  smb_st_e       st, nxt;
  logic [3:0]    bitc;
  logic          got;
  logic [7:0]    shreg;
  logic [7:0]    txsh;
  logic [7:0]    cmd;
  logic [PW-1:0] ptr;
  logic [7:0]    remain;
  logic          first_cnt;
  logic          macked;
  logic [7:0]    cnt_val;
  logic [7:0]    tx_next;

  // Pointer stops at its top value so it never wraps back into the bank
  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == '1) ? p : p + PW'(1);
  endfunction

  assign cnt_val = (ptr < PW'(NREG)) ? 8'(PW'(NREG) - ptr) : 8'h00;
  assign tx_next = first_cnt ? cnt_val : rd_data;
  assign rd_addr = ptr;
  assign st_o    = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      bitc      <= '0;
      got       <= 1'b0;
      shreg     <= '0;
      txsh      <= '0;
      cmd       <= '0;
      ptr       <= '0;
      remain    <= '0;
      first_cnt <= 1'b0;
      macked    <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        bitc   <= '0;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD, ST_CNT, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_q};
              bitc  <= bitc + 4'd1;
              if (bitc == 4'd7) got <= 1'b1;
            end else if (scl_fall && got) begin
              got  <= 1'b0;
              bitc <= '0;
              case (st)
                ST_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    st     <= ST_ACK;
                    if (shreg[0]) begin
                      nxt       <= ST_TX;
                      ptr       <= PW'(cmd[6:0]);
                      first_cnt <= ~cmd[7];
                    end else begin
                      nxt <= ST_CMD;
                    end
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                ST_CMD: begin
                  cmd    <= shreg;
                  ptr    <= PW'(shreg[6:0]);
                  remain <= shreg[7] ? 8'd1 : 8'd0;
                  nxt    <= shreg[7] ? ST_WDAT : ST_CNT;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
                ST_CNT: begin
                  remain <= shreg;
                  nxt    <= ST_WDAT;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
                default: begin // ST_WDAT
                  if (remain != 8'd0) begin
                    remain  <= remain - 8'd1;
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= shreg;
                    ptr     <= bump(ptr);
                    sda_oe  <= 1'b1;
                    nxt     <= ST_WDAT;
                    st      <= ST_ACK;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitc <= '0;
              st   <= nxt;
              if (nxt == ST_TX) begin
                txsh      <= tx_next;
                sda_oe    <= ~tx_next[7];
                if (!first_cnt) ptr <= bump(ptr);
                first_cnt <= 1'b0;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitc <= bitc + 4'd1;
            end else if (scl_fall) begin
              if (bitc == 4'd8) begin
                sda_oe <= 1'b0;
                bitc   <= '0;
                st     <= ST_MACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              macked <= ~sda_q;
            end else if (scl_fall) begin
              if (macked) begin
                st     <= ST_TX;
                txsh   <= tx_next;
                sda_oe <= ~tx_next[7];
                ptr    <= bump(ptr);
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ; // ST_IDLE, ST_SKIP wait for start or stop
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h6B,
  parameter int                NREG        = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] RST_VAL     = 64'h00_00_00_00_00_00_00_00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);

  localparam int PW = 8;

  logic          sda_q;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          wr_en;
  logic [PW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [PW-1:0] rd_addr;
  logic [7:0]    rd_data;
  smb_st_e       fsm_st;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smb_protocol #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .PW(PW)) u_proto (
    .clk      (clk),
    .rst      (rst),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe),
    .st_o     (fsm_st)
  );

  smb_reg_bank #(.NREG(NREG), .PW(PW), .RST_VAL(RST_VAL)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .regs_o (regs_o)
  );

endmodule

// File: rtl/smb_regfile_chk.sv
module smb_regfile_chk
  import smb_pkg::*;
#(
  parameter int                NREG    = 8,
  parameter logic [NREG*8-1:0] RST_VAL = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input smb_st_e           st,
  input logic [NREG*8-1:0] regs_o
);

  // R1: first cycle out of reset shows the default image
  p_defaults_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs_o == RST_VAL));

  // R2: no drive while idle or ignoring the bus
  p_quiet_when_skipping_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe);

  // R3: a stop always releases the line
  p_release_on_stop_r3: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R10: drive changes follow a clock fall or a bus condition
  p_sda_moves_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R9: registers change only right after an acknowledged data byte
  p_regs_follow_ack_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs_o) |-> ($past(st) == ST_ACK));

endmodule

bind smb_regfile smb_regfile_chk #(.NREG(NREG), .RST_VAL(RST_VAL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .scl_fall (scl_fall),
  .start_det(start_det),
  .stop_det (stop_det),
  .st       (fsm_st),
  .regs_o   (regs_o)
);

// File: tb/tb_smb_regfile.sv
`timescale 1ns/1ps
module tb_smb_regfile;

  localparam int          NREG    = 8;
  localparam logic [63:0] RST_VAL = 64'h7E_00_FF_11_22_C3_5A_01;
  localparam int          Q       = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smb_regfile #(.NREG(NREG), .RST_VAL(RST_VAL)) dut (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_m),
    .sda_i (sda_bus),
    .sda_oe(sda_oe),
    .regs_o(regs_o)
  );

  int         checks = 0;
  int         fails  = 0;
  logic [7:0] model [NREG];
  bit         cmp_on = 1'b0;
  bit         pend_v = 1'b0;
  int         pend_i = 0;
  logic [7:0] pend_d = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_img();
    logic [63:0] v = '0;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_reg(input int off);
    return (off < NREG) ? model[off] : 8'h00;
  endfunction

  // Reference register image compared every clock while SCL is high (R9)
  always @(negedge clk) begin
    if (cmp_on && scl_m) chk("R9 register image", regs_o, model_img());
  end

  task automatic clk_bit(input bit b, output bit seen);
    repeat (Q) @(negedge clk);
    sda_m = b;
    repeat (Q) @(negedge clk);
    scl_m = 1'b1;
    if (pend_v) begin
      model[pend_i] = pend_d;
      pend_v = 1'b0;
    end
    repeat (Q) @(negedge clk);
    seen = sda_bus;
    repeat (Q - 1) @(negedge clk);
    chk("R10 SDA steady while SCL high", sda_bus, seen);
    @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic start_c();
    repeat (2) @(negedge clk);
    sda_m = 1'b1;
    repeat (Q) @(negedge clk);
    scl_m = 1'b1;
    repeat (Q) @(negedge clk);
    sda_m = 1'b0;
    repeat (Q) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    repeat (2) @(negedge clk);
    sda_m = 1'b0;
    repeat (Q) @(negedge clk);
    scl_m = 1'b1;
    repeat (Q) @(negedge clk);
    sda_m = 1'b1;
    repeat (2 * Q) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit wr,
                           input int idx, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    if (wr) begin
      pend_v = 1'b1;
      pend_i = idx;
      pend_d = b;
    end
    clk_bit(1'b1, s);
    chk(req, {63'd0, ~s}, {63'd0, exp_ack});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
    bit s;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    chk(req, v, exp);
    clk_bit(~mack, s);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d, input bit extra,
                            input logic [7:0] d2);
    start_c();
    send_byte(8'hD6, 1'b1, 1'b0, 0, "R2 address ack");
    send_byte({1'b1, 7'(off)}, 1'b1, 1'b0, 0, "R4 command ack");
    send_byte(d, 1'b1, off < NREG, off, "R4 R8 data ack");
    if (extra) send_byte(d2, 1'b0, 1'b0, 0, "R4 second data NACK");
    stop_c();
  endtask

  task automatic byte_read(input int off, input string req);
    start_c();
    send_byte(8'hD6, 1'b1, 1'b0, 0, "R2 address ack");
    send_byte({1'b1, 7'(off)}, 1'b1, 1'b0, 0, "R5 command ack");
    start_c();
    send_byte(8'hD7, 1'b1, 1'b0, 0, "R3 repeated start address ack");
    recv_byte(exp_reg(off), 1'b0, req);
    stop_c();
  endtask

  task automatic block_write(input int off, input int n, input int m,
                             input logic [7:0] base, input string req);
    start_c();
    send_byte(8'hD6, 1'b1, 1'b0, 0, "R2 address ack");
    send_byte({1'b0, 7'(off)}, 1'b1, 1'b0, 0, "R6 command ack");
    send_byte(8'(n), 1'b1, 1'b0, 0, "R6 count ack");
    for (int k = 0; k < m; k++) begin
      send_byte(base + 8'(17 * k), k < n, (k < n) && (off + k < NREG), off + k, req);
    end
    stop_c();
  endtask

  task automatic block_read(input int off, input int m, input string req);
    start_c();
    send_byte(8'hD6, 1'b1, 1'b0, 0, "R2 address ack");
    send_byte({1'b0, 7'(off)}, 1'b1, 1'b0, 0, "R7 command ack");
    start_c();
    send_byte(8'hD7, 1'b1, 1'b0, 0, "R3 repeated start address ack");
    recv_byte((off < NREG) ? 8'(NREG - off) : 8'h00, m > 0, "R7 byte count");
    for (int k = 0; k < m; k++) recv_byte(exp_reg(off + k), k < m - 1, req);
    stop_c();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit s;
    for (int i = 0; i < NREG; i++) model[i] = RST_VAL[i*8 +: 8];
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset image", regs_o, RST_VAL);
    chk("R1 SDA released after reset", {63'd0, sda_oe}, 64'd0);
    cmp_on = 1'b1;

    byte_read(2, "R5 byte read of default");
    byte_write(5, 8'h3C, 1'b1, 8'hEE);
    byte_read(5, "R5 byte read after write");

    block_write(0, 8, 8, 8'h10, "R6 block data ack");
    block_read(0, 8, "R7 block data");
    block_read(5, 3, "R7 block data from offset 5");

    block_write(6, 2, 4, 8'hA0, "R6 data past count NACK");
    block_read(6, 2, "R7 block data after partial");

    block_write(2, 4, 2, 8'h55, "R9 aborted block data");
    block_read(2, 4, "R9 readback after abort");

    byte_write(9, 8'hAA, 1'b0, 8'h00);
    byte_read(9, "R8 out of bank byte read");
    block_read(9, 2, "R8 out of bank block read");
    block_write(7, 3, 3, 8'hC1, "R8 block write crossing bank end");
    block_read(7, 1, "R8 last register after crossing write");

    // Foreign address: no ack for it or the following bytes
    start_c();
    send_byte(8'hA6, 1'b0, 1'b0, 0, "R2 foreign address NACK");
    send_byte(8'h83, 1'b0, 1'b0, 0, "R2 ignored byte after mismatch");
    send_byte(8'h5A, 1'b0, 1'b0, 0, "R2 ignored data after mismatch");
    stop_c();
    byte_read(3, "R2 register untouched by foreign transfer");

    // Start inside a byte restarts address reception
    start_c();
    clk_bit(1'b1, s);
    clk_bit(1'b0, s);
    clk_bit(1'b1, s);
    byte_write(3, 8'h96, 1'b0, 8'h00);
    byte_read(3, "R3 write after restart mid-byte");

    block_read(0, 8, "R7 final block image");
    chk("R10 SDA released at end", {63'd0, sda_oe}, 64'd0);

    cmp_on = 1'b0;
    finish_run();
  end

endmodule